// File: doc/BRIEF.md
# Strobed Controller with Input and Output Holding Registers

This block is a small sequencing controller whose inputs and outputs both pass through registers. The outputs therefore never show the short spikes that a decoder can produce while several state bits switch at once. Everything runs from a single fast base clock. A phase counter divides this clock into three single-cycle enables:

- a state tick, which advances the state register once per state period;
- a synchronizing strobe, which fires `SYNC_RATIO` times per state period and loads the two asynchronous request pins into an input holding register;
- an output strobe, which fires `OUT_PHASE` base cycles after each state tick and loads the decoded outputs into an output holding register once the decoders have settled.

The controller runs a short demonstration job:

| State | Code | Next state |
|-------|------|------------|
| idle  | 000  | arm when a start request is held |
| arm   | 001  | run |
| run   | 011  | drain when a stop request is held |
| drain | 010  | flush |
| flush | 110  | done |
| done  | 111  | idle |

The done-to-idle step switches three bits at once. The codes were chosen so that every branch that depends on an asynchronous input flips exactly one bit. The block has no data stream, so every pin is a plain level and there is no valid/ready handshake or back-pressure.

Top module: `glitchfree_ctrl`

## Requirements
- R1: A synchronous reset (`rst` high at a clock edge) clears the phase counter, the state register (to idle, 000), the input holding register and the output holding register. All four outputs read 0 from the first base-clock edge taken with `rst` high.
- R2: The state register changes only on the state tick, which occurs once every `STATE_DIV` base cycles. Two output changes are therefore never fewer than `STATE_DIV` base cycles apart.
- R3: The next-state logic sees the request pins only through the input holding register. That register is loaded only on the synchronizing strobe, which fires `SYNC_RATIO` times per state period.
- R4: The outputs change only on the base-clock edge at which the phase counter equals `OUT_PHASE`. Counting edges from 0 at the first edge after reset is released, this is edge index e with e mod `STATE_DIV` == `OUT_PHASE`, and `OUT_PHASE` lies in 1..`STATE_DIV`-1.
- R5: Each registered output value is the decode of the settled state. The output bits are packed as {done, flush, motor, busy}:
  - bit0 `busy_o` is high in every state except idle;
  - bit1 `motor_o` is high in run (011);
  - bit2 `flush_o` is high in drain (010) and flush (110);
  - bit3 `done_o` is high in done (111).
- R6: The state sequence is:
  - idle goes to arm (001) on a held start;
  - arm goes to run (011);
  - run goes to drain (010) on a held stop;
  - drain goes to flush (110), flush to done (111), and done to idle;
  - the unused codes 100 and 101 go to idle.

  The registered output values therefore step 0000, 0001, 0011, 0101, 1001, 0000.
- R7: `busy_o` stays high without a drop across every transition from arm through done. It falls only when the machine leaves done.
- R8: A stop request has no effect in idle. A start request has no effect in any state other than idle.
- R9: A state change out of a branch that depends on an input (idle or run) flips at most one state bit.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Base clock; every register and strobe is derived from it |
| rst | input | 1 | Synchronous reset, active high |
| start_i | input | 1 | Asynchronous start request |
| stop_i | input | 1 | Asynchronous stop request |
| busy_o | output | 1 | Registered: a job is in progress |
| motor_o | output | 1 | Registered: run phase active |
| flush_o | output | 1 | Registered: drain or flush phase active |
| done_o | output | 1 | Registered: final phase of the job |

## Verification
The controller is driven with four request patterns:

- a stop request alone while idle, which must leave every output untouched;
- a plain start followed later by a stop, which walks the whole job;
- a start repeated while the job is running, which must be ignored;
- start and stop raised together, which shows that stop is only acted on after the machine has reached run.

A scoreboard compares every output change against the expected code sequence. The same check catches an extra or missing step, and it also catches a transient value caused by the three-bit done-to-idle step.

For each output change the bench also checks two timing rules: the change must fall on the output-strobe phase of the base-clock count, and it must come no sooner than a full state period after the previous change. These checks separate a correctly delayed strobe from one placed on the state edge. A reset asserted in the middle of a job confirms that every register clears.

// File: rtl/gfc_pkg.sv
package gfc_pkg;

  // State codes: the branch from idle and the branch from run each step
  // by one bit, since both depend on an asynchronous request.
  typedef enum logic [2:0] {
    ST_IDLE  = 3'b000,
    ST_ARM   = 3'b001,
    ST_RUN   = 3'b011,
    ST_DRAIN = 3'b010,
    ST_FLUSH = 3'b110,
    ST_DONE  = 3'b111
  } gfc_state_e;

  typedef struct packed {
    logic stop;
    logic start;
  } gfc_req_t;

  typedef struct packed {
    logic done;
    logic flush;
    logic motor;
    logic busy;
  } gfc_outs_t;

  localparam int unsigned REQ_W = $bits(gfc_req_t);

endpackage

// File: rtl/gfc_strobe_gen.sv
module gfc_strobe_gen #(
  parameter int unsigned STATE_DIV  = 8,
  parameter int unsigned SYNC_RATIO = 4,
  parameter int unsigned OUT_PHASE  = 3
) (
  input  logic clk,
  input  logic rst,
  output logic state_tick,
  output logic sync_stb,
  output logic out_stb
);

  localparam int unsigned CW   = (STATE_DIV > 1) ? $clog2(STATE_DIV) : 1;
  localparam int unsigned SPAN = STATE_DIV / SYNC_RATIO;
  localparam logic [CW-1:0] LAST  = CW'(STATE_DIV - 1);
  localparam logic [CW-1:0] PHASE = CW'(OUT_PHASE);

  logic [CW-1:0] phase_q;

  always_ff @(posedge clk) begin
    if (rst)                 phase_q <= '0;
    else if (phase_q == LAST) phase_q <= '0;
    else                     phase_q <= phase_q + 1'b1;
  end

  assign state_tick = (phase_q == LAST);
  assign out_stb    = (phase_q == PHASE);

  // Synchronizing strobe: every base cycle when the span is one,
  // otherwise a sub-counter realigned to each state period.
  generate
    if (SPAN <= 1) begin : g_sync_every
      assign sync_stb = 1'b1;
    end else begin : g_sync_div
      localparam int unsigned SW = $clog2(SPAN);
      localparam logic [SW-1:0] SUB_LAST = SW'(SPAN - 1);
      logic [SW-1:0] sub_q;
      always_ff @(posedge clk) begin
        if (rst || state_tick)     sub_q <= '0;
        else if (sub_q == SUB_LAST) sub_q <= '0;
        else                       sub_q <= sub_q + 1'b1;
      end
      assign sync_stb = (sub_q == '0);
    end
  endgenerate

endmodule

// File: rtl/gfc_in_hold.sv
module gfc_in_hold #(
  parameter int unsigned W      = 2,
  parameter int unsigned STAGES = 2
) (
  input  logic         clk,
  input  logic         rst,
  input  logic         en,
  input  logic [W-1:0] d,
  output logic [W-1:0] q
);

  logic [W-1:0] stage_q [STAGES];

  generate
    for (genvar g = 0; g < STAGES; g++) begin : g_stage
      logic [W-1:0] src;
      if (g == 0) begin : g_first
        assign src = d;
      end else begin : g_next
        assign src = stage_q[g-1];
      end
      always_ff @(posedge clk) begin
        if (rst)     stage_q[g] <= '0;
        else if (en) stage_q[g] <= src;
      end
    end
  endgenerate

  assign q = stage_q[STAGES-1];

endmodule

// File: rtl/gfc_decode.sv
module gfc_decode
  import gfc_pkg::*;
(
  input  gfc_state_e cur,
  input  gfc_req_t   req,
  output gfc_state_e nxt,
  output gfc_outs_t  outs
);

  always_comb begin
    nxt = ST_IDLE;
    unique case (cur)
      ST_IDLE:  nxt = req.start ? ST_ARM : ST_IDLE;
      ST_ARM:   nxt = ST_RUN;
      ST_RUN:   nxt = req.stop ? ST_DRAIN : ST_RUN;
      ST_DRAIN: nxt = ST_FLUSH;
      ST_FLUSH: nxt = ST_DONE;
      ST_DONE:  nxt = ST_IDLE;
      default:  nxt = ST_IDLE;
    endcase
  end

  always_comb begin
    outs       = '0;
    outs.busy  = (cur != ST_IDLE);
    outs.motor = (cur == ST_RUN);
    outs.flush = (cur == ST_DRAIN) || (cur == ST_FLUSH);
    outs.done  = (cur == ST_DONE);
  end

endmodule

// File: rtl/gfc_out_hold.sv
module gfc_out_hold
  import gfc_pkg::*;
(
  input  logic      clk,
  input  logic      rst,
  input  logic      en,
  input  gfc_outs_t d,
  output gfc_outs_t q
);

  always_ff @(posedge clk) begin
    if (rst)     q <= '0;
    else if (en) q <= d;
  end

endmodule

// File: rtl/glitchfree_ctrl.sv
module glitchfree_ctrl
  import gfc_pkg::*;
#(
  parameter int unsigned STATE_DIV   = 8,
  parameter int unsigned SYNC_RATIO  = 4,
  parameter int unsigned OUT_PHASE   = 3,
  parameter int unsigned SYNC_STAGES = 2
) (
  input  logic clk,
  input  logic rst,
  input  logic start_i,
  input  logic stop_i,
  output logic busy_o,
  output logic motor_o,
  output logic flush_o,
  output logic done_o
);

  logic       state_tick;
  logic       sync_stb;
  logic       out_stb;
  gfc_req_t   raw_req;
  gfc_req_t   held_q;
  gfc_state_e state_q;
  gfc_state_e state_nxt;
  gfc_outs_t  outs_dec;
  gfc_outs_t  outs_q;

  gfc_strobe_gen #(
    .STATE_DIV (STATE_DIV),
    .SYNC_RATIO(SYNC_RATIO),
    .OUT_PHASE (OUT_PHASE)
  ) u_strobe (
    .clk       (clk),
    .rst       (rst),
    .state_tick(state_tick),
    .sync_stb  (sync_stb),
    .out_stb   (out_stb)
  );

  assign raw_req.start = start_i;
  assign raw_req.stop  = stop_i;

  gfc_in_hold #(
    .W     (REQ_W),
    .STAGES(SYNC_STAGES)
  ) u_in_hold (
    .clk(clk),
    .rst(rst),
    .en (sync_stb),
    .d  (raw_req),
    .q  (held_q)
  );

  gfc_decode u_decode (
    .cur (state_q),
    .req (held_q),
    .nxt (state_nxt),
    .outs(outs_dec)
  );

  always_ff @(posedge clk) begin
    if (rst)             state_q <= ST_IDLE;
    else if (state_tick) state_q <= state_nxt;
  end

  gfc_out_hold u_out_hold (
    .clk(clk),
    .rst(rst),
    .en (out_stb),
    .d  (outs_dec),
    .q  (outs_q)
  );

  assign busy_o  = outs_q.busy;
  assign motor_o = outs_q.motor;
  assign flush_o = outs_q.flush;
  assign done_o  = outs_q.done;

endmodule

// File: rtl/gfc_checker.sv
module gfc_checker (
  input logic       clk,
  input logic       rst,
  input logic       state_tick,
  input logic       sync_stb,
  input logic       out_stb,
  input logic [2:0] state_q,
  input logic [1:0] held_q,
  input logic [3:0] outs_q
);

  AST_RESET_CLEARS: assert property (@(posedge clk)
    rst |=> (outs_q == 4'b0000 && state_q == 3'b000 && held_q == 2'b00)); // R1

  AST_STATE_ON_TICK: assert property (@(posedge clk) disable iff (rst)
    !state_tick |=> $stable(state_q)); // R2

  AST_HOLD_ON_SYNC: assert property (@(posedge clk) disable iff (rst)
    !sync_stb |=> $stable(held_q)); // R3

  AST_OUT_ON_STROBE: assert property (@(posedge clk) disable iff (rst)
    !out_stb |=> $stable(outs_q)); // R4

  AST_STROBES_APART: assert property (@(posedge clk) disable iff (rst)
    state_tick |-> !out_stb); // R4

  AST_OUT_MATCHES_STATE: assert property (@(posedge clk) disable iff (rst)
    out_stb |=> (outs_q[0] == ($past(state_q) != 3'b000)) &&
                (outs_q[3] == ($past(state_q) == 3'b111))); // R5

  AST_BUSY_FALLS_FROM_DONE: assert property (@(posedge clk) disable iff (rst)
    $fell(outs_q[0]) |-> $past(outs_q[3])); // R7

  AST_UNIT_BRANCH: assert property (@(posedge clk) disable iff (rst)
    (state_tick && (state_q == 3'b000 || state_q == 3'b011))
      |=> ($countones(state_q ^ $past(state_q)) <= 1)); // R9

endmodule

bind glitchfree_ctrl gfc_checker u_gfc_checker (
  .clk       (clk),
  .rst       (rst),
  .state_tick(state_tick),
  .sync_stb  (sync_stb),
  .out_stb   (out_stb),
  .state_q   (state_q),
  .held_q    (held_q),
  .outs_q    (outs_q)
);

// File: tb/glitchfree_ctrl_bench.sv
`timescale 1ns/1ps
module glitchfree_ctrl_bench;

  localparam int DIV   = 8;
  localparam int PHASE = 3;
  localparam logic [3:0] O_IDLE  = 4'b0000;
  localparam logic [3:0] O_ARM   = 4'b0001;
  localparam logic [3:0] O_RUN   = 4'b0011;
  localparam logic [3:0] O_DRAIN = 4'b0101;
  localparam logic [3:0] O_DONE  = 4'b1001;

  logic clk = 1'b0;
  logic rst = 1'b1;
  logic start_i = 1'b0;
  logic stop_i = 1'b0;
  logic busy_o, motor_o, flush_o, done_o;

  always #4 clk = ~clk;

  glitchfree_ctrl u_glitchfree_ctrl (
    .clk(clk), .rst(rst), .start_i(start_i), .stop_i(stop_i),
    .busy_o(busy_o), .motor_o(motor_o), .flush_o(flush_o), .done_o(done_o)
  );

  wire [3:0] obs = {done_o, flush_o, motor_o, busy_o};

  int checks = 0;
  int errors = 0;
  int edge_n = 0;
  int last_change = -100;
  bit ended = 1'b0;
  logic [3:0] prev_out = 4'b0000;
  logic [3:0] exp_q[$];

  task automatic chk(input bit ok, input string req, input int act, input int exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  task automatic finish_run();
    ended = 1'b1;
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  endtask

  task automatic wait_periods(input int n);
    repeat (n * DIV) @(negedge clk);
  endtask

  always @(posedge clk) begin
    if (rst) edge_n <= 0;
    else     edge_n <= edge_n + 1;
  end

  // Monitor: every output change is timed and popped from the scoreboard.
  always @(negedge clk) begin
    if (rst) begin
      prev_out    = 4'b0000;
      last_change = -100;
    end else if (!ended && obs !== prev_out) begin
      int e;
      logic [3:0] want;
      e = edge_n - 1;
      chk((e % DIV) == PHASE, "R4 change phase", e % DIV, PHASE);
      chk((e - last_change) >= DIV, "R2 change spacing", e - last_change, DIV);
      if (exp_q.size() == 0) begin
        chk(1'b0, "R6 unexpected output change", int'(obs), int'(prev_out));
      end else begin
        want = exp_q.pop_front();
        chk(obs == want, "R5 R6 output code", int'(obs), int'(want));
      end
      if (prev_out[0] && !obs[0])
        chk(prev_out == O_DONE, "R7 busy fell outside done", int'(prev_out), int'(O_DONE));
      last_change = e;
      prev_out    = obs;
    end
  end

  initial begin
    repeat (20000) @(posedge clk);
    if (!ended) begin
      errors++;
      $display("FAIL watchdog expired actual=running expected=finished");
      finish_run();
    end
  end

  initial begin
    repeat (4) @(negedge clk);
    chk(obs == 4'b0000, "R1 outputs during reset", int'(obs), 0);
    rst = 1'b0;
    wait_periods(3);
    chk(obs == O_IDLE, "R1 idle after reset", int'(obs), int'(O_IDLE));

    // R8: stop while idle is ignored
    stop_i = 1'b1;
    wait_periods(2);
    stop_i = 1'b0;
    wait_periods(3);
    chk(obs == O_IDLE && exp_q.size() == 0, "R8 stop in idle", int'(obs), int'(O_IDLE));

    // R6: plain start, then later stop
    exp_q.push_back(O_ARM);
    exp_q.push_back(O_RUN);
    start_i = 1'b1;
    wait_periods(3);
    start_i = 1'b0;
    wait_periods(3);
    chk(obs == O_RUN, "R6 reached run", int'(obs), int'(O_RUN));
    chk(exp_q.size() == 0, "R3 start taken once", exp_q.size(), 0);

    // R8: start while running is ignored
    start_i = 1'b1;
    wait_periods(2);
    start_i = 1'b0;
    wait_periods(3);
    chk(obs == O_RUN, "R8 start in run", int'(obs), int'(O_RUN));

    exp_q.push_back(O_DRAIN);
    exp_q.push_back(O_DONE);
    exp_q.push_back(O_IDLE);
    stop_i = 1'b1;
    wait_periods(2);
    stop_i = 1'b0;
    wait_periods(8);
    chk(obs == O_IDLE, "R6 back to idle from done", int'(obs), int'(O_IDLE));
    chk(exp_q.size() == 0, "R6 full job walked", exp_q.size(), 0);

    // Start and stop together: stop acts only once run is reached
    exp_q.push_back(O_ARM);
    exp_q.push_back(O_RUN);
    exp_q.push_back(O_DRAIN);
    exp_q.push_back(O_DONE);
    exp_q.push_back(O_IDLE);
    start_i = 1'b1;
    stop_i  = 1'b1;
    wait_periods(2);
    start_i = 1'b0;
    wait_periods(2);
    stop_i = 1'b0;
    wait_periods(8);
    chk(obs == O_IDLE && exp_q.size() == 0, "R8 R6 joint requests", int'(obs), int'(O_IDLE));

    // R1: reset in the middle of a job
    exp_q.push_back(O_ARM);
    exp_q.push_back(O_RUN);
    start_i = 1'b1;
    wait_periods(3);
    start_i = 1'b0;
    wait_periods(1);
    chk(obs == O_RUN, "R6 run before reset", int'(obs), int'(O_RUN));
    rst = 1'b1;
    @(negedge clk);
    chk(obs == 4'b0000, "R1 reset clears outputs", int'(obs), 0);
    repeat (2) @(negedge clk);
    rst = 1'b0;
    wait_periods(4);
    chk(obs == O_IDLE && exp_q.size() == 0, "R1 stays idle after reset", int'(obs), int'(O_IDLE));

    finish_run();
  end

endmodule